// File: doc/BRIEF.md
# Audio Serial Clock and Frame Clock Generator

This block runs on the audio master clock (MCLK). It divides that clock into a free-running bit clock (SCLK) and a frame clock (LRCK) for an audio serial port acting as clock host. A three-bit ratio select chooses how many MCLK cycles make up one sample period. The standard ratios use 64 bit clocks per frame. The ratios meant for 12, 24 or 48 MHz USB-derived master clocks are 125, 250 and 272, and these may give an uneven LRCK duty cycle.

Next to the two clock levels, the block gives a serializer two single-cycle strobes in the MCLK domain. One marks each SCLK falling edge. The other marks the first MCLK cycle of each frame, which is the point where LRCK returns to its first-half level. While enabled, the clocks run without gaps from frame to frame. A new ratio takes effect only at a frame boundary, so a frame never has a mixed length.

Top module: `aclk_clkgen`

## Requirements
- R1: While reset is asserted, and in every cycle after an edge at which `en` is sampled low, `sclk`, `lrck`, `sclk_fall` and `frame_start` are all low.
- R2: `ratio_sel` selects the MCLK cycles per frame with this encoding: 0=125, 1=128, 2=192, 3=250, 4=256, 5=272, 6=384, 7=512. The distance between consecutive `frame_start` pulses equals the selected ratio.
- R3: The SCLK period is D MCLK cycles. D is 2, 3, 4, 6, 8 for ratios 128, 192, 256, 384, 512; D is 1, 2, 4 for ratios 125, 250, 272. Within each period SCLK is high for floor(D/2) cycles, ending the period. `sclk_fall` pulses once per period, in the first low cycle. With D=1, `sclk` stays low and `sclk_fall` is high every cycle.
- R4: Each frame holds N SCLK periods: 64 for the standard ratios, 125 for ratios 125 and 250, and 68 for ratio 272.
- R5: `lrck` is low for the first floor(N/2) SCLK periods of a frame and high for the remaining N-floor(N/2). It changes only in a cycle where `sclk_fall` is high.
- R6: `frame_start` is high for exactly one MCLK cycle per frame. That cycle also has `sclk_fall` high, and it is the cycle in which `lrck` goes from high to low.
- R7: After the first edge that samples `en` high, `frame_start` is high in the very next cycle.
- R8: A change of `ratio_sel` during a frame does not alter that frame's length. The new ratio governs the frame that begins at the next `frame_start`.
- R9: While `en` stays high, frames follow one another with no idle cycles, and every frame has the same length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Runs the generator when high; holds it idle when low |
| ratio_sel | input | 3 | MCLK-per-frame ratio code (see R2) |
| sclk | output | 1 | Bit clock level |
| lrck | output | 1 | Frame clock level; low in the first half of a frame |
| sclk_fall | output | 1 | One-cycle strobe in the first low cycle of each SCLK period |
| frame_start | output | 1 | One-cycle strobe in the first cycle of each frame |

## Verification
The frame wrap and the bit-clock falling edge always land in the same MCLK cycle, together with the LRCK fall. The bench sweeps all eight ratio codes for three frames each, and at every frame start it checks that the fall strobe is high, that LRCK is low, and that LRCK was high one cycle before. A second overlap is a ratio change that arrives in the middle of a frame, with the boundary that applies it still ahead. This case is provoked by switching 128 to 512 and then 512 to 125 part-way through a frame. The bench judges it by the lengths of the old and the following frames.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
    localparam int SEL_W     = 3;
    localparam int MAX_DIV   = 8;
    localparam int MAX_SLOTS = 125;
    localparam int DIV_W     = $clog2(MAX_DIV + 1);
    localparam int PH_W      = $clog2(MAX_DIV);
    localparam int SLOT_W    = $clog2(MAX_SLOTS);

    typedef enum logic [SEL_W-1:0] {
        RATIO_125 = 3'd0,
        RATIO_128 = 3'd1,
        RATIO_192 = 3'd2,
        RATIO_250 = 3'd3,
        RATIO_256 = 3'd4,
        RATIO_272 = 3'd5,
        RATIO_384 = 3'd6,
        RATIO_512 = 3'd7
    } ratio_sel_e;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [SLOT_W-1:0] slots;
    } ratio_cfg_t;

    typedef struct packed {
        logic              run;
        logic [SEL_W-1:0]  sel;
        logic [PH_W-1:0]   phase;
        logic [SLOT_W-1:0] slot;
    } cnt_state_t;

    typedef struct packed {
        logic sclk;
        logic lrck;
        logic sclk_fall;
        logic frame_start;
    } pin_state_t;
endpackage

// File: rtl/aclk_ratio_decode.sv
module aclk_ratio_decode
    import aclk_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    output ratio_cfg_t       cfg_o
);
    always_comb begin
        unique case (ratio_sel_e'(sel_i))
            RATIO_125: cfg_o = '{div: DIV_W'(1), slots: SLOT_W'(125)};
            RATIO_128: cfg_o = '{div: DIV_W'(2), slots: SLOT_W'(64)};
            RATIO_192: cfg_o = '{div: DIV_W'(3), slots: SLOT_W'(64)};
            RATIO_250: cfg_o = '{div: DIV_W'(2), slots: SLOT_W'(125)};
            RATIO_256: cfg_o = '{div: DIV_W'(4), slots: SLOT_W'(64)};
            RATIO_272: cfg_o = '{div: DIV_W'(4), slots: SLOT_W'(68)};
            RATIO_384: cfg_o = '{div: DIV_W'(6), slots: SLOT_W'(64)};
            default:   cfg_o = '{div: DIV_W'(8), slots: SLOT_W'(64)};
        endcase
    end
endmodule

// File: rtl/aclk_pin_decode.sv
module aclk_pin_decode
    import aclk_pkg::*;
(
    input  logic              run_i,
    input  logic [PH_W-1:0]   phase_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  ratio_cfg_t        cfg_i,
    output pin_state_t        pins_o
);
    logic [DIV_W-1:0]  high_from;
    logic [SLOT_W-1:0] second_half;

    always_comb begin
        // high part sits at the end of each period, floor(div/2) cycles long
        high_from   = cfg_i.div - (cfg_i.div >> 1);
        second_half = cfg_i.slots >> 1;

        pins_o.sclk        = run_i && (DIV_W'(phase_i) >= high_from);
        pins_o.lrck        = run_i && (slot_i >= second_half);
        pins_o.sclk_fall   = run_i && (phase_i == '0);
        pins_o.frame_start = run_i && (phase_i == '0) && (slot_i == '0);
    end
endmodule

// File: rtl/aclk_clkgen.sv
module aclk_clkgen
    import aclk_pkg::*;
(
    input  logic             mclk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             sclk,
    output logic             lrck,
    output logic             sclk_fall,
    output logic             frame_start
);
    cnt_state_t st_d, st_q;
    pin_state_t pin_d, pin_q;
    ratio_cfg_t cfg_q, cfg_d;
    logic       last_phase, last_slot;

    aclk_ratio_decode u_cfg_cur (
        .sel_i (st_q.sel),
        .cfg_o (cfg_q)
    );

    aclk_ratio_decode u_cfg_nxt (
        .sel_i (st_d.sel),
        .cfg_o (cfg_d)
    );

    aclk_pin_decode u_pins (
        .run_i   (st_d.run),
        .phase_i (st_d.phase),
        .slot_i  (st_d.slot),
        .cfg_i   (cfg_d),
        .pins_o  (pin_d)
    );

    always_comb begin
        last_phase = (DIV_W'(st_q.phase) == (cfg_q.div - DIV_W'(1)));
        last_slot  = (st_q.slot == (cfg_q.slots - SLOT_W'(1)));
        st_d       = st_q;

        if (!en) begin
            st_d     = '0;
            st_d.sel = ratio_sel;
        end else if (!st_q.run) begin
            st_d.run   = 1'b1;
            st_d.sel   = ratio_sel;
            st_d.phase = '0;
            st_d.slot  = '0;
        end else if (last_phase) begin
            st_d.phase = '0;
            if (last_slot) begin
                st_d.slot = '0;
                st_d.sel  = ratio_sel;   // ratio switches only at the frame boundary
            end else begin
                st_d.slot = st_q.slot + SLOT_W'(1);
            end
        end else begin
            st_d.phase = st_q.phase + PH_W'(1);
        end
    end

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            pin_q <= '0;
        end else begin
            st_q  <= st_d;
            pin_q <= pin_d;
        end
    end

    assign sclk        = pin_q.sclk;
    assign lrck        = pin_q.lrck;
    assign sclk_fall   = pin_q.sclk_fall;
    assign frame_start = pin_q.frame_start;
endmodule

// File: rtl/aclk_clkgen_chk.sv
module aclk_clkgen_chk (
    input logic mclk,
    input logic rst_n,
    input logic en,
    input logic sclk,
    input logic lrck,
    input logic sclk_fall,
    input logic frame_start
);
    assert_disable_idle_R1: assert property (@(posedge mclk) disable iff (!rst_n)
        !en |=> (!sclk && !lrck && !sclk_fall && !frame_start));

    assert_fall_in_low_R3: assert property (@(posedge mclk) disable iff (!rst_n)
        sclk_fall |-> !sclk);

    assert_fall_marked_R3: assert property (@(posedge mclk) disable iff (!rst_n)
        $fell(sclk) |-> sclk_fall);

    assert_lr_rise_on_fall_R5: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(lrck) |-> sclk_fall);

    assert_start_aligned_R6: assert property (@(posedge mclk) disable iff (!rst_n)
        frame_start |-> (sclk_fall && !lrck));

    assert_lr_fall_is_start_R6: assert property (@(posedge mclk) disable iff (!rst_n)
        ($fell(lrck) && $past(en)) |-> frame_start);
endmodule

bind aclk_clkgen aclk_clkgen_chk u_chk (
    .mclk        (mclk),
    .rst_n       (rst_n),
    .en          (en),
    .sclk        (sclk),
    .lrck        (lrck),
    .sclk_fall   (sclk_fall),
    .frame_start (frame_start)
);

// File: tb/aclk_clkgen_tb.sv
module aclk_clkgen_tb;
    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] ratio_sel = 3'd0;
    logic       sclk, lrck, sclk_fall, frame_start;
    int         n_chk = 0;
    int         n_fail = 0;

    always #4 mclk = ~mclk;

    aclk_clkgen u_dut (
        .mclk        (mclk),
        .rst_n       (rst_n),
        .en          (en),
        .ratio_sel   (ratio_sel),
        .sclk        (sclk),
        .lrck        (lrck),
        .sclk_fall   (sclk_fall),
        .frame_start (frame_start)
    );

    function automatic int ratio_of(input int sel);
        int tbl[8] = '{125, 128, 192, 250, 256, 272, 384, 512};
        return tbl[sel];
    endfunction

    function automatic int div_of(input int sel);
        int r = ratio_of(sel);
        if (r % 64 == 0) return r / 64;
        if (r == 125) return 1;
        if (r == 250) return 2;
        return 4;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        chk(!sclk && !lrck && !sclk_fall && !frame_start, req, "idle outputs",
            {sclk, lrck, sclk_fall, frame_start}, 0);
    endtask

    // called in a cycle where frame_start is high; walks one frame and checks it
    task automatic walk_frame(input int sel, input bool_first, output int len);
        int d = div_of(sel);
        int n = ratio_of(sel) / d;
        int falls = 0, shi = 0, llo = 0, gap = 0, gap_bad = 0;
        bit prev_l = 1'b0;
        len = 0;
        do begin
            if (sclk_fall) begin
                if (len > 0 && gap != d) gap_bad++;
                falls++;
                gap = 0;
            end
            if (sclk) shi++;
            if (!lrck) llo++;
            prev_l = lrck;
            @(negedge mclk);
            len++;
            gap++;
        end while (!frame_start);
        chk(len == d * n, "R2", "frame length", len, d * n);
        chk(gap_bad == 0, "R3", "sclk period mismatches", gap_bad, 0);
        chk(shi == n * (d / 2), "R3", "sclk high cycles", shi, n * (d / 2));
        chk(falls == n, "R4", "sclk periods per frame", falls, n);
        chk(llo == (n / 2) * d, "R5", "lrck low cycles", llo, (n / 2) * d);
        chk(prev_l == 1'b1, "R6", "lrck before frame start", prev_l, 1);
        chk(sclk_fall && !lrck, "R6", "fall strobe and low lrck at start",
            {sclk_fall, lrck}, 2);
    endtask

    task automatic sweep(input int sel);
        int len, first_len;
        en = 1'b0;
        ratio_sel = 3'(sel);
        repeat (3) @(negedge mclk);
        check_idle("R1");
        en = 1'b1;
        @(negedge mclk);
        chk(frame_start == 1'b1, "R7", "frame_start after enable", frame_start, 1);
        first_len = 0;
        for (int f = 0; f < 3; f++) begin
            walk_frame(sel, 1'b0, len);
            if (f == 0) first_len = len;
            else chk(len == first_len, "R9", "steady frame length", len, first_len);
        end
    endtask

    initial begin
        repeat (200000) @(posedge mclk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int len;
        en = 1'b1;
        ratio_sel = 3'd1;
        repeat (4) @(negedge mclk);
        check_idle("R1");
        rst_n = 1'b1;

        for (int s = 0; s < 8; s++) sweep(s);

        // R8: change 128 -> 512 in the middle of a frame
        en = 1'b0;
        ratio_sel = 3'd1;
        repeat (2) @(negedge mclk);
        en = 1'b1;
        @(negedge mclk);
        repeat (10) @(negedge mclk);
        ratio_sel = 3'd7;
        len = 10;
        do begin
            @(negedge mclk);
            len++;
        end while (!frame_start);
        chk(len == 128, "R8", "old frame kept length", len, 128);
        walk_frame(7, 1'b0, len);
        chk(len == 512, "R8", "new ratio at next frame", len, 512);

        // R8: change 512 -> 125 well inside a frame
        repeat (300) @(negedge mclk);
        ratio_sel = 3'd0;
        len = 300;
        do begin
            @(negedge mclk);
            len++;
        end while (!frame_start);
        chk(len == 512, "R8", "old frame kept length", len, 512);
        walk_frame(0, 1'b0, len);
        chk(len == 125, "R8", "new ratio at next frame", len, 125);

        // R1: dropping enable idles the outputs on the next cycle
        en = 1'b0;
        @(negedge mclk);
        check_idle("R1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule